// File: doc/BRIEF.md
# EDO Page-Mode DRAM Controller with Byte Lanes

This controller sits between a synchronous single-word request port and an asynchronous 256K x 16 DRAM with extended data-out. Each request carries an 18-bit word address, write data, a per-byte enable mask and a read/write flag, and it is accepted with a valid/ready handshake. The controller places the upper nine address bits on the shared DRAM address pins as the row and the lower nine bits as the column. It keeps the row open between requests so that later accesses to the same row need only a column cycle.

Every write is an early write. The write strobe is low one full clock before any column strobe falls, and output enable stays high. Each byte of the word has its own column strobe, so a byte write pulses only the strobe for the enabled lane. Read data is held on the pins after the column strobe rises. The controller therefore shortens the column-strobe pulse to its minimum width and captures read data during the precharge that follows, once the access time has elapsed.

A refresh request input takes priority over new requests. It closes the open row, waits out the row precharge, and runs a column-before-row refresh. A counter of row-strobe low time forces the page closed before the row-strobe low-time limit is reached. Timings are parameters counted in clock cycles. The reset input is asynchronous and active low, and it is expected to be released in step with the clock.

Top module: `edo_page_ctrl`

## Requirements
- R1: During and right after reset, the row strobe, both column strobes, write strobe and output enable are high (inactive), the data driver is off, rd_valid and ref_ack are low, and no row is activated before T_RP cycles have passed.
- R2: On a row activation the DRAM address pins carry req_addr[17:9]. On each column strobe fall they carry req_addr[8:0].
- R3: req_be[0] selects lane 0 (bits 7:0, dram_cas_n[0]) and req_be[1] selects lane 1 (bits 15:8, dram_cas_n[1]); only enabled lanes' strobes fall. On a read, the rd_data lanes that are not enabled read as zero.
- R4: A request whose row equals the open row is served with no new row activation.
- R5: A request to a different row, or a refresh, raises the row strobe. The row strobe then stays high for at least T_RP cycles before it falls again.
- R6: On a write, the write strobe is low in the cycle before any column strobe falls and stays low while it falls; output enable is high and the data driver is on.
- R7: Between the fall of the row strobe and the first column strobe fall there are at least T_RCD cycles. Between the rise of the column strobes and their next fall there are at least T_CP cycles.
- R8: A read returns its data with a one-cycle rd_valid pulse. The data is captured at least T_ACC cycles after the column strobe fell. A write produces no rd_valid.
- R9: While ref_req is high, req_ready is low. The refresh lowers both column strobes at least T_CSR cycles before the row strobe falls. ref_ack is a one-cycle pulse, and it comes before any pending request is activated.
- R10: The row strobe is never low for more than RAS_LIMIT consecutive cycles, even with an idle open page.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted in this cycle when valid |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 18 | Word address, row in the upper half |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Byte lane enables |
| rd_valid | output | 1 | Read data valid pulse |
| rd_data | output | 16 | Read data |
| ref_req | input | 1 | Refresh request, held until acknowledged |
| ref_ack | output | 1 | Refresh done pulse |
| dram_addr | output | 9 | Multiplexed row/column address |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 2 | Column strobes per lane, active low |
| dram_we_n | output | 1 | Write strobe, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_dq_out | output | 16 | Data toward the DRAM |
| dram_dq_oe | output | 1 | Drive enable for dram_dq_out |
| dram_dq_in | input | 16 | Data from the DRAM |

## Verification
Refresh arbitration and request acceptance can fall in the same cycle. The bench provokes this by raising ref_req and req_valid on the same edge while the row is closed. It then judges the order: the column-before-row refresh must appear on the pins and be acknowledged before the request's row activation, and the read must still return the right word. A second collision comes from an open page left idle. The low-time counter and a page hit compete for the open row, and the bench checks that the row strobe rises before its limit while the next request reopens the row with correct data.

// File: rtl/edo_ctrl_pkg.sv
package edo_ctrl_pkg;

  typedef enum logic [3:0] {
    ST_PRE,
    ST_IDLE,
    ST_ACT,
    ST_COL,
    ST_CASLO,
    ST_CASPRE,
    ST_OPEN,
    ST_REFC,
    ST_REFR
  } edo_state_t;

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/edo_wait_cnt.sv
// Down counter: loaded with N-1 on entry, done while it reads zero.
module edo_wait_cnt #(
  parameter int W       = 4,
  parameter int RST_VAL = 0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] val,
  output logic         done
);
  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)              cnt_d = val;
    else if (cnt_q != '0)  cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= W'(RST_VAL);
    else        cnt_q <= cnt_d;
  end

  assign done = (cnt_q == '0);
endmodule

// File: rtl/edo_page_track.sv
// Holds the row of the open page and compares it with a probe row.
module edo_page_track #(
  parameter int W = 9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         capture,
  input  logic [W-1:0] row_in,
  input  logic [W-1:0] probe,
  output logic         hit
);
  logic [W-1:0] row_q, row_d;

  always_comb row_d = capture ? row_in : row_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) row_q <= '0;
    else        row_q <= row_d;
  end

  assign hit = (row_q == probe);
endmodule

// File: rtl/edo_ras_window.sv
// Counts consecutive row-strobe low cycles and flags the close point.
module edo_ras_window #(
  parameter int W        = 15,
  parameter int CLOSE_AT = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ras_low,
  output logic near_end
);
  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = '0;
    if (ras_low) cnt_d = (cnt_q == {W{1'b1}}) ? cnt_q : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign near_end = (cnt_q >= W'(CLOSE_AT));
endmodule

// File: rtl/edo_page_ctrl.sv
module edo_page_ctrl
  import edo_ctrl_pkg::*;
#(
  parameter int HALF_W    = 9,
  parameter int DATA_W    = 16,
  parameter int T_RCD     = 5,
  parameter int T_CAS     = 3,
  parameter int T_CP      = 3,
  parameter int T_ACC     = 8,
  parameter int T_RP      = 9,
  parameter int T_CSR     = 3,
  parameter int T_RFS     = 15,
  parameter int RAS_LIMIT = 24000
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic                  req_we,
  input  logic [2*HALF_W-1:0]   req_addr,
  input  logic [DATA_W-1:0]     req_wdata,
  input  logic [DATA_W/8-1:0]   req_be,
  output logic                  rd_valid,
  output logic [DATA_W-1:0]     rd_data,
  input  logic                  ref_req,
  output logic                  ref_ack,
  output logic [HALF_W-1:0]     dram_addr,
  output logic                  dram_ras_n,
  output logic [DATA_W/8-1:0]   dram_cas_n,
  output logic                  dram_we_n,
  output logic                  dram_oe_n,
  output logic [DATA_W-1:0]     dram_dq_out,
  output logic                  dram_dq_oe,
  input  logic [DATA_W-1:0]     dram_dq_in
);
  localparam int LANES    = DATA_W / 8;
  localparam int RD_PRE   = imax(T_CP, T_ACC - T_CAS);
  localparam int TMR_MAX  = imax(imax(imax(T_RCD, T_CAS), imax(RD_PRE, T_RP)),
                                 imax(T_CSR, T_RFS));
  localparam int TMR_W    = $clog2(TMR_MAX + 1);
  localparam int WIN_W    = $clog2(RAS_LIMIT + 1);
  localparam int CLOSE_AT = RAS_LIMIT - (T_CAS + RD_PRE + 4);

  edo_state_t state_q, state_d;
  logic             tmr_load, tmr_done, accept, page_cap, rd_cap, ack_d;
  logic [TMR_W-1:0] tmr_val;
  logic             row_hit, near_end;

  logic              cmd_we_q, cmd_we_d;
  logic [LANES-1:0]  cmd_be_q, cmd_be_d;
  logic [HALF_W-1:0] cmd_col_q, cmd_col_d;
  logic [DATA_W-1:0] cmd_wd_q, cmd_wd_d;

  logic              ras_low_d, we_low_d, oe_low_d;
  logic [LANES-1:0]  cas_low_d;
  logic [HALF_W-1:0] addr_q, addr_d;
  logic              ras_n_q, we_n_q, oe_n_q, dq_oe_q;
  logic [LANES-1:0]  cas_n_q;
  logic [DATA_W-1:0] rdat_q, rdat_d;
  logic              rdv_q, ack_q;

  edo_wait_cnt #(.W(TMR_W), .RST_VAL(T_RP - 1)) u_tmr (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .val(tmr_val), .done(tmr_done));

  edo_page_track #(.W(HALF_W)) u_page (
    .clk(clk), .rst_n(rst_n), .capture(page_cap),
    .row_in(req_addr[2*HALF_W-1:HALF_W]), .probe(req_addr[2*HALF_W-1:HALF_W]),
    .hit(row_hit));

  edo_ras_window #(.W(WIN_W), .CLOSE_AT(CLOSE_AT)) u_win (
    .clk(clk), .rst_n(rst_n), .ras_low(!ras_n_q), .near_end(near_end));

  // Sequencer: next state and timer loads
  always_comb begin
    state_d  = state_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    accept   = 1'b0;
    page_cap = 1'b0;
    rd_cap   = 1'b0;
    ack_d    = 1'b0;
    unique case (state_q)
      ST_PRE:  if (tmr_done) state_d = ST_IDLE;
      ST_IDLE: begin
        if (ref_req) begin
          state_d = ST_REFC; tmr_load = 1'b1; tmr_val = TMR_W'(T_CSR - 1);
        end else if (req_valid) begin
          accept = 1'b1; page_cap = 1'b1; state_d = ST_ACT;
          tmr_load = 1'b1; tmr_val = TMR_W'(T_RCD - 1);
        end
      end
      ST_ACT:  if (tmr_done) state_d = ST_COL;
      ST_COL: begin
        state_d = ST_CASLO; tmr_load = 1'b1; tmr_val = TMR_W'(T_CAS - 1);
      end
      ST_CASLO: if (tmr_done) begin
        state_d  = ST_CASPRE; tmr_load = 1'b1;
        tmr_val  = cmd_we_q ? TMR_W'(T_CP - 1) : TMR_W'(RD_PRE - 1);
      end
      ST_CASPRE: if (tmr_done) begin
        state_d = ST_OPEN; rd_cap = !cmd_we_q;
      end
      ST_OPEN: begin
        if (ref_req || near_end || (req_valid && !row_hit)) begin
          state_d = ST_PRE; tmr_load = 1'b1; tmr_val = TMR_W'(T_RP - 1);
        end else if (req_valid) begin
          accept = 1'b1; state_d = ST_COL;
        end
      end
      ST_REFC: if (tmr_done) begin
        state_d = ST_REFR; tmr_load = 1'b1; tmr_val = TMR_W'(T_RFS - 1);
      end
      ST_REFR: if (tmr_done) begin
        state_d = ST_PRE; tmr_load = 1'b1; tmr_val = TMR_W'(T_RP - 1); ack_d = 1'b1;
      end
      default: state_d = ST_PRE;
    endcase
  end

  assign req_ready = !ref_req &&
                     ((state_q == ST_IDLE) || (state_q == ST_OPEN && !near_end && row_hit));

  // Command capture with accept as clock enable
  always_comb begin
    cmd_we_d  = accept ? req_we                  : cmd_we_q;
    cmd_be_d  = accept ? req_be                  : cmd_be_q;
    cmd_col_d = accept ? req_addr[HALF_W-1:0]    : cmd_col_q;
    cmd_wd_d  = accept ? req_wdata               : cmd_wd_q;
  end

  // Pin decode from the next state
  always_comb begin
    ras_low_d = state_d inside {ST_ACT, ST_COL, ST_CASLO, ST_CASPRE, ST_OPEN, ST_REFR};
    we_low_d  = cmd_we_d && (state_d inside {ST_COL, ST_CASLO});
    oe_low_d  = !cmd_we_d && (state_d inside {ST_CASLO, ST_CASPRE});
    addr_d    = addr_q;
    if (page_cap)              addr_d = req_addr[2*HALF_W-1:HALF_W];
    else if (state_d == ST_COL) addr_d = cmd_col_d;
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    always_comb begin
      cas_low_d[l] = ((state_d == ST_CASLO) && cmd_be_d[l]) ||
                     (state_d inside {ST_REFC, ST_REFR});
      rdat_d[8*l +: 8] = rdat_q[8*l +: 8];
      if (rd_cap) rdat_d[8*l +: 8] = cmd_be_q[l] ? dram_dq_in[8*l +: 8] : 8'h00;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_PRE;
      cmd_we_q  <= 1'b0;
      cmd_be_q  <= '0;
      cmd_col_q <= '0;
      cmd_wd_q  <= '0;
      addr_q    <= '0;
      ras_n_q   <= 1'b1;
      cas_n_q   <= '1;
      we_n_q    <= 1'b1;
      oe_n_q    <= 1'b1;
      dq_oe_q   <= 1'b0;
      rdat_q    <= '0;
      rdv_q     <= 1'b0;
      ack_q     <= 1'b0;
    end else begin
      state_q   <= state_d;
      cmd_we_q  <= cmd_we_d;
      cmd_be_q  <= cmd_be_d;
      cmd_col_q <= cmd_col_d;
      cmd_wd_q  <= cmd_wd_d;
      addr_q    <= addr_d;
      ras_n_q   <= !ras_low_d;
      cas_n_q   <= ~cas_low_d;
      we_n_q    <= !we_low_d;
      oe_n_q    <= !oe_low_d;
      dq_oe_q   <= we_low_d;
      rdat_q    <= rdat_d;
      rdv_q     <= rd_cap;
      ack_q     <= ack_d;
    end
  end

  assign dram_addr   = addr_q;
  assign dram_ras_n  = ras_n_q;
  assign dram_cas_n  = cas_n_q;
  assign dram_we_n   = we_n_q;
  assign dram_oe_n   = oe_n_q;
  assign dram_dq_out = cmd_wd_q;
  assign dram_dq_oe  = dq_oe_q;
  assign rd_data     = rdat_q;
  assign rd_valid    = rdv_q;
  assign ref_ack     = ack_q;
endmodule

// File: rtl/edo_ctrl_chk.sv
module edo_ctrl_chk #(
  parameter int LANES     = 2,
  parameter int T_RCD     = 5,
  parameter int T_CP      = 3,
  parameter int T_RP      = 9,
  parameter int RAS_LIMIT = 24000
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ras_n,
  input logic [LANES-1:0] cas_n,
  input logic             we_n,
  input logic             oe_n,
  input logic             req_ready,
  input logic             ref_req,
  input logic             rd_valid,
  input logic             ref_ack
);
  logic [31:0]      hi_cnt, lo_cnt, cas_hi_cnt;
  logic [LANES-1:0] cas_prev;
  logic             we_prev;
  logic             cas_fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_cnt     <= '0;
      lo_cnt     <= '0;
      cas_hi_cnt <= '0;
      cas_prev   <= '1;
      we_prev    <= 1'b1;
    end else begin
      hi_cnt     <= ras_n  ? ((hi_cnt == 32'hFFFF_FFFF) ? hi_cnt : hi_cnt + 1) : '0;
      lo_cnt     <= !ras_n ? ((lo_cnt == 32'hFFFF_FFFF) ? lo_cnt : lo_cnt + 1) : '0;
      cas_hi_cnt <= (&cas_n) ? ((cas_hi_cnt == 32'hFFFF_FFFF) ? cas_hi_cnt : cas_hi_cnt + 1) : '0;
      cas_prev   <= cas_n;
      we_prev    <= we_n;
    end
  end

  assign cas_fall = |(cas_prev & ~cas_n);

  assert_ras_prech_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> hi_cnt >= T_RP);
  assert_rcd_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cas_fall && !ras_n) |-> lo_cnt >= T_RCD);
  assert_cas_prech_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cas_fall && !ras_n) |-> cas_hi_cnt >= T_CP);
  assert_early_we_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cas_fall && !we_n) |-> !we_prev);
  assert_oe_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |-> oe_n);
  assert_ras_limit_R10: assert property (@(posedge clk) disable iff (!rst_n)
    lo_cnt <= RAS_LIMIT);
  assert_ref_blocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ref_req |-> !req_ready);
  assert_ack_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ref_ack |=> !ref_ack);
  assert_rdv_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);
endmodule

bind edo_page_ctrl edo_ctrl_chk #(
  .LANES(DATA_W/8), .T_RCD(T_RCD), .T_CP(T_CP), .T_RP(T_RP), .RAS_LIMIT(RAS_LIMIT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .ras_n(dram_ras_n), .cas_n(dram_cas_n),
  .we_n(dram_we_n), .oe_n(dram_oe_n), .req_ready(req_ready), .ref_req(ref_req),
  .rd_valid(rd_valid), .ref_ack(ref_ack)
);

// File: tb/sim_edo_page_ctrl.sv
`timescale 1ns/1ps
module sim_edo_page_ctrl;
  localparam int T_RCD = 5, T_CP = 3, T_ACC = 8, T_RP = 9, T_CSR = 3;
  localparam int LIMIT = 200;
  localparam int NV = 12;
  // {we, miss, be[1:0], addr[17:0], data[15:0]}
  localparam logic [37:0] VEC [NV] = '{
    {1'b1, 1'b1, 2'b11, 18'h00010, 16'h1234},
    {1'b1, 1'b0, 2'b11, 18'h00011, 16'hABCD},
    {1'b0, 1'b0, 2'b11, 18'h00010, 16'h1234},
    {1'b1, 1'b0, 2'b01, 18'h00010, 16'h9955},
    {1'b0, 1'b0, 2'b11, 18'h00010, 16'h1255},
    {1'b1, 1'b0, 2'b10, 18'h00010, 16'h77AA},
    {1'b0, 1'b0, 2'b11, 18'h00011, 16'hABCD},
    {1'b1, 1'b1, 2'b11, 18'h20010, 16'hCAFE},
    {1'b0, 1'b0, 2'b11, 18'h20010, 16'hCAFE},
    {1'b0, 1'b1, 2'b11, 18'h00010, 16'h7755},
    {1'b0, 1'b0, 2'b01, 18'h00010, 16'h0055},
    {1'b0, 1'b0, 2'b10, 18'h00011, 16'hAB00}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_we = 1'b0, ref_req = 1'b0;
  logic [17:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [1:0]  req_be = '0;
  logic req_ready, rd_valid, ref_ack;
  logic [15:0] rd_data;
  logic [8:0]  dram_addr;
  logic dram_ras_n, dram_we_n, dram_oe_n, dram_dq_oe;
  logic [1:0]  dram_cas_n;
  logic [15:0] dram_dq_out, dram_dq_in;

  always #2 clk = ~clk;

  edo_page_ctrl #(.RAS_LIMIT(LIMIT)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
    .rd_valid(rd_valid), .rd_data(rd_data), .ref_req(ref_req), .ref_ack(ref_ack),
    .dram_addr(dram_addr), .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n),
    .dram_we_n(dram_we_n), .dram_oe_n(dram_oe_n), .dram_dq_out(dram_dq_out),
    .dram_dq_oe(dram_dq_oe), .dram_dq_in(dram_dq_in));

  int errors = 0, checks = 0, cyc = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Behavioural DRAM model and pin monitor
  logic [15:0] mem [logic [17:0]];
  logic [8:0]  m_row = '0, m_col = '0;
  logic [1:0]  held = '0, last_mask = '0, prev_cas = '1;
  logic        prev_ras = 1'b1, prev_we = 1'b1;
  int acc = 0, act_cnt = 0, cbr_cnt = 0, act_t = 0, cbr_t = 0;
  int hi_run = 0, lo_run = 0, cas_hi_run = 0, max_lo = 0;
  int tviol = 0, ewviol = 0, csr_viol = 0, cas_lo_ref = 0;

  always @(posedge clk) begin
    logic [1:0] fall;
    cyc++;
    if (rst_n) begin
      fall = prev_cas & ~dram_cas_n;
      if (prev_ras && !dram_ras_n) begin
        if (&(~dram_cas_n)) begin
          cbr_cnt++; cbr_t = cyc;
          if (cas_lo_ref < T_CSR) csr_viol++;
        end else begin
          act_cnt++; act_t = cyc; m_row = dram_addr;
          if (hi_run < T_RP) tviol++;
        end
      end
      if (dram_ras_n) held = '0;
      if ((|fall) && !dram_ras_n) begin
        m_col = dram_addr; last_mask = fall; held = fall; acc = 1;
        if (lo_run < T_RCD) tviol++;
        if (cas_hi_run < T_CP) tviol++;
        if (!dram_we_n) begin
          logic [15:0] w;
          if (prev_we) ewviol++;
          if (!dram_oe_n || !dram_dq_oe) ewviol++;
          w = mem.exists({m_row, dram_addr}) ? mem[{m_row, dram_addr}] : 16'h0000;
          if (fall[0]) w[7:0]  = dram_dq_out[7:0];
          if (fall[1]) w[15:8] = dram_dq_out[15:8];
          mem[{m_row, dram_addr}] = w;
        end
      end else if (acc < 1000) acc++;
      cas_lo_ref = (&(~dram_cas_n)) ? cas_lo_ref + 1 : 0;
      hi_run     = dram_ras_n ? hi_run + 1 : 0;
      lo_run     = dram_ras_n ? 0 : lo_run + 1;
      if (lo_run > max_lo) max_lo = lo_run;
      cas_hi_run = (&dram_cas_n) ? cas_hi_run + 1 : 0;
      prev_ras = dram_ras_n; prev_cas = dram_cas_n; prev_we = dram_we_n;
    end
  end

  always @* begin
    logic [15:0] word;
    word = mem.exists({m_row, m_col}) ? mem[{m_row, m_col}] : 16'h0000;
    for (int l = 0; l < 2; l++)
      dram_dq_in[8*l +: 8] = (!dram_ras_n && !dram_oe_n && dram_we_n && held[l] &&
                              acc >= T_ACC - 1) ? word[8*l +: 8] : 8'hA5;
  end

  // Pulse and handshake monitor (away from the active edge)
  int rdv_viol = 0, rdy_viol = 0;
  logic rdv_prev = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (rd_valid && rdv_prev) rdv_viol++;
      if (ref_req && req_ready) rdy_viol++;
    end
    rdv_prev = rd_valid;
  end

  // Watchdog
  always @(posedge clk) begin
    if (cyc == 100000) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic run_op(input logic [37:0] v);
    logic we, miss;
    logic [1:0] be;
    logic [17:0] a;
    logic [15:0] d, rv;
    int a0;
    bit got;
    we = v[37]; miss = v[36]; be = v[35:34]; a = v[33:16]; d = v[15:0];
    a0 = act_cnt; got = 0; rv = '0;
    @(negedge clk);
    req_valid = 1'b1; req_we = we; req_addr = a; req_wdata = d; req_be = be;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    for (int k = 0; k < 16; k++) begin
      if (rd_valid) begin got = 1; rv = rd_data; end
      @(negedge clk);
    end
    chk((act_cnt - a0) == int'(miss), "R4/R5 activations", act_cnt - a0, miss);
    chk(m_col == a[8:0], "R2 column", m_col, a[8:0]);
    if (miss) chk(m_row == a[17:9], "R2 row", m_row, a[17:9]);
    chk(last_mask == be, "R3 lane strobes", last_mask, be);
    if (we) chk(!got, "R8 no rd_valid on write", got, 0);
    else begin
      chk(got, "R8 rd_valid", got, 1);
      chk(rv == d, "R3/R8 read data", rv, d);
    end
  endtask

  initial begin
    int c0, k;
    bit got;
    logic [15:0] rv;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(dram_ras_n == 1'b1, "R1 ras_n", dram_ras_n, 1);
    chk(dram_cas_n == 2'b11, "R1 cas_n", dram_cas_n, 2'b11);
    chk(dram_we_n && dram_oe_n, "R1 we_n/oe_n", {dram_we_n, dram_oe_n}, 2'b11);
    chk(!dram_dq_oe && !rd_valid && !ref_ack, "R1 drivers/pulses",
        {dram_dq_oe, rd_valid, ref_ack}, 0);
    rst_n = 1'b1;
    // R1: no activation before precharge window
    for (int i = 0; i < T_RP - 1; i++) begin
      @(negedge clk);
      if (req_ready) begin chk(0, "R1 ready during precharge", 1, 0); break; end
    end
    chk(act_cnt == 0, "R1 no early activation", act_cnt, 0);

    for (int i = 0; i < NV; i++) run_op(VEC[i]);

    // R9: refresh closes open page, CBR, ack pulse
    c0 = cbr_cnt;
    @(negedge clk); ref_req = 1'b1;
    k = 0;
    while (!ref_ack && k < 200) begin @(negedge clk); k++; end
    ref_req = 1'b0;
    chk(ref_ack, "R9 ref_ack", ref_ack, 1);
    chk(cbr_cnt == c0 + 1, "R9 CBR cycle", cbr_cnt, c0 + 1);
    chk(dram_ras_n, "R5 row closed after refresh", dram_ras_n, 1);
    run_op({1'b0, 1'b1, 2'b11, 18'h00010, 16'h7755});

    // R9: refresh and request in the same cycle from a closed row
    repeat (LIMIT + 20) @(negedge clk);
    chk(dram_ras_n, "R10 idle page closed", dram_ras_n, 1);
    @(negedge clk);
    ref_req = 1'b1; req_valid = 1'b1; req_we = 1'b0; req_addr = 18'h20010; req_be = 2'b11;
    k = 0;
    while (!ref_ack && k < 200) begin @(negedge clk); k++; end
    ref_req = 1'b0;
    chk(ref_ack, "R9 ref_ack on collision", ref_ack, 1);
    while (!req_ready) @(negedge clk);
    @(negedge clk); req_valid = 1'b0;
    got = 0; rv = '0;
    for (int j = 0; j < 20; j++) begin
      if (rd_valid) begin got = 1; rv = rd_data; end
      @(negedge clk);
    end
    chk(cbr_t < act_t, "R9 refresh before activation", cbr_t, act_t);
    chk(got && rv == 16'hCAFE, "R9 read after refresh", rv, 16'hCAFE);

    // R10: idle open page forced closed before the limit
    repeat (LIMIT * 2) @(negedge clk);
    chk(dram_ras_n, "R10 forced close", dram_ras_n, 1);
    chk(max_lo <= LIMIT, "R10 longest ras low", max_lo, LIMIT);
    run_op({1'b0, 1'b1, 2'b11, 18'h20011, 16'h0000});

    chk(tviol == 0, "R5/R7 timing violations", tviol, 0);
    chk(ewviol == 0, "R6 early write violations", ewviol, 0);
    chk(csr_viol == 0, "R9 CAS-before-RAS setup", csr_viol, 0);
    chk(rdv_viol == 0, "R8 rd_valid pulse width", rdv_viol, 0);
    chk(rdy_viol == 0, "R9 ready under refresh", rdy_viol, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule